// File: doc/BRIEF.md
# Page-Mode Read Buffer

This block fronts a slow memory array that delivers a whole page in one transfer. A host presents a byte-granular read address together with a chip select and an output enable. The block keeps one page in a local buffer. A read that falls outside the buffered page starts a random access. The block drives the page number to the array, waits a fixed number of clocks, captures the full page in one step and returns the requested item. A read inside the buffered page is answered one clock later, and the items of that page may be read in any order.

A page holds four 16-bit words, which is eight bytes, and starts on an 8-byte boundary. Address bit 0 is the extra byte-select bit. In word mode, bits 2..1 pick the word and bit 0 has no effect. In byte mode, bits 2..0 pick the byte. Bits 3 and up form the page number. Dropping chip select throws the buffer away, so the next selected read is always a random access, even to the same page. A strobe marks the cycles in which the output data is good.

Top module: `page_read_buffer`

## Requirements
- R1: While reset is asserted and after it is released, rd_valid and arr_req are 0. The first selected read after reset is a random access.
- R2: A selected read (chip_sel=1, out_en=1) to a page that is not buffered raises arr_req one clock later, with arr_page equal to rd_addr[ADDR_W-1:3]. rd_valid stays 0 until exactly RAND_LAT clock edges after the request was first sampled, and then shows the requested item of the fetched page. arr_req is never high for more than RAND_LAT-1 cycles in a row for one page.
- R3: A read whose page number differs from the buffered page causes a full random access.
- R4: Deasserting chip_sel and then asserting it again causes a full random access, even when the page number is unchanged.
- R5: A selected read inside the buffered page returns its data with rd_valid=1 one clock edge later, in any order of offsets, with arr_req staying 0.
- R6: In word mode (byte_mode=0), offset bits rd_addr[2:1]=w return page bits [16w+15:16w], and rd_addr[0] has no effect.
- R7: In byte mode (byte_mode=1), rd_addr[2:0]=k returns page bits [8k+7:8k] on rd_data[7:0], and rd_data[15:8] is 0.
- R8: If the page number changes while a random access is in progress, the access restarts. arr_page follows the new page, rd_valid stays 0, and the new page's data is valid RAND_LAT edges after the change.
- R9: rd_valid is 0 in any cycle that follows a cycle with chip_sel=0 or out_en=0. With chip_sel held high, the buffer stays usable across out_en low.
- R10: Deasserting chip_sel during a random access abandons it, and arr_req is 0 on the next cycle.
- R11: While a random access runs and the page number is unchanged, arr_page holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip select, active high; low discards the buffer |
| out_en | input | 1 | Output enable, active high |
| byte_mode | input | 1 | 1 = byte reads, 0 = word reads |
| rd_addr | input | ADDR_W | Byte address; bit 0 is the extra byte-select bit |
| rd_data | output | DATA_W | Read data; byte reads are zero-extended |
| rd_valid | output | 1 | Read data valid strobe |
| arr_req | output | 1 | Random access in progress towards the array |
| arr_page | output | ADDR_W-3 | Page number presented to the array |
| arr_data | input | 4*DATA_W | Full page returned by the array for arr_page |

## Verification
Two events can land on the same clock edge. One is the final edge of a random access, where the page is captured. The other is a new address arriving, either as a page change or as a deselect. Both compete for the fetch sequencer. The bench moves the page number two edges into a fetch and drops chip select one edge into another. It then judges that arr_page follows the new page, that rd_valid stays low for the whole restarted latency, and that the data finally shown comes from the new page and not from the abandoned one.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } prb_fetch_st_e;

  localparam int unsigned PRB_DEF_ADDR_W = 20;
  localparam int unsigned PRB_DEF_DATA_W = 16;
  localparam int unsigned PRB_DEF_WORDS  = 4;
  localparam int unsigned PRB_DEF_LAT    = 4;
endpackage

// File: rtl/prb_fetch_seq.sv
module prb_fetch_seq
  import prb_pkg::*;
#(
  parameter int unsigned PG_W = 17,
  parameter int unsigned LAT  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_sel,
  input  logic            rd_act,
  input  logic            hit,
  input  logic [PG_W-1:0] req_page,
  output logic            busy,
  output logic [PG_W-1:0] fetch_page,
  output logic            load
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  prb_fetch_st_e    st_q, st_n;
  logic [PG_W-1:0]  pg_q, pg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pg_en, cnt_en;

  // next-state logic
  always_comb begin
    st_n   = st_q;
    pg_n   = pg_q;
    cnt_n  = cnt_q;
    pg_en  = 1'b0;
    cnt_en = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (rd_act && !hit) begin
          st_n   = FS_FETCH;
          pg_n   = req_page;
          pg_en  = 1'b1;
          cnt_n  = CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      FS_FETCH: begin
        if (!chip_sel) begin
          st_n = FS_IDLE;
        end else if (req_page != pg_q) begin
          pg_n   = req_page;
          pg_en  = 1'b1;
          cnt_n  = CNT_ONE;
          cnt_en = 1'b1;
        end else if (cnt_q == CNT_LAST) begin
          load = 1'b1;
          st_n = FS_IDLE;
        end else begin
          cnt_n  = CNT_W'(cnt_q + 1'b1);
          cnt_en = 1'b1;
        end
      end
      default: st_n = FS_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      pg_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_n;
      if (pg_en)  pg_q  <= pg_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy       = (st_q == FS_FETCH);
  assign fetch_page = pg_q;
endmodule

// File: rtl/prb_tag_track.sv
module prb_tag_track #(
  parameter int unsigned PG_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_sel,
  input  logic            load,
  input  logic [PG_W-1:0] load_page,
  input  logic [PG_W-1:0] req_page,
  output logic            hit
);
  logic            tag_v_q, tag_v_n;
  logic [PG_W-1:0] tag_q;

  always_comb begin
    tag_v_n = chip_sel ? (tag_v_q | load) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_v_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      tag_v_q <= tag_v_n;
      if (load) tag_q <= load_page;
    end
  end

  assign hit = tag_v_q && (tag_q == req_page);
endmodule

// File: rtl/prb_page_store.sv
module prb_page_store #(
  parameter int unsigned PAGE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (load) begin
      page_q <= page_in;
    end
  end
endmodule

// File: rtl/prb_lane_sel.sv
module prb_lane_sel #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned OFF_W  = 3
) (
  input  logic [WORDS*DATA_W-1:0] page_i,
  input  logic                    byte_mode_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic [DATA_W-1:0]       data_o
);
  localparam int unsigned BYTES  = WORDS * DATA_W / 8;
  localparam int unsigned WIDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] word_lane [WORDS];
  logic [7:0]        byte_lane [BYTES];
  logic [WIDX_W-1:0] word_idx;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_lane[w] = page_i[w*DATA_W +: DATA_W];
  end
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_lane[b] = page_i[b*8 +: 8];
  end

  assign word_idx = off_i[OFF_W-1 -: WIDX_W];

  always_comb begin
    if (byte_mode_i) data_o = DATA_W'(byte_lane[off_i]);
    else             data_o = word_lane[word_idx];
  end
endmodule

// File: rtl/page_read_buffer.sv
module page_read_buffer
  import prb_pkg::*;
#(
  parameter int unsigned ADDR_W   = PRB_DEF_ADDR_W,
  parameter int unsigned DATA_W   = PRB_DEF_DATA_W,
  parameter int unsigned WORDS    = PRB_DEF_WORDS,
  parameter int unsigned RAND_LAT = PRB_DEF_LAT,
  localparam int unsigned PAGE_W  = WORDS * DATA_W,
  localparam int unsigned OFF_W   = $clog2(PAGE_W / 8),
  localparam int unsigned PG_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              out_en,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              arr_req,
  output logic [PG_W-1:0]   arr_page,
  input  logic [PAGE_W-1:0] arr_data
);
  logic              rd_act, hit, busy, load;
  logic [PG_W-1:0]   req_page, fetch_page;
  logic [OFF_W-1:0]  req_off;
  logic [PAGE_W-1:0] buf_page, sel_src;
  logic [DATA_W-1:0] sel_data, data_n;
  logic              valid_n, data_en;

  assign rd_act   = chip_sel && out_en;
  assign req_page = rd_addr[ADDR_W-1:OFF_W];
  assign req_off  = rd_addr[OFF_W-1:0];

  prb_tag_track #(.PG_W(PG_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_sel (chip_sel),
    .load     (load),
    .load_page(fetch_page),
    .req_page (req_page),
    .hit      (hit)
  );

  prb_fetch_seq #(.PG_W(PG_W), .LAT(RAND_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .rd_act    (rd_act),
    .hit       (hit),
    .req_page  (req_page),
    .busy      (busy),
    .fetch_page(fetch_page),
    .load      (load)
  );

  prb_page_store #(.PAGE_W(PAGE_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .page_in(arr_data),
    .page_q (buf_page)
  );

  // the completing fetch feeds the output straight from the array
  assign sel_src = load ? arr_data : buf_page;

  prb_lane_sel #(.DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W)) u_sel (
    .page_i     (sel_src),
    .byte_mode_i(byte_mode),
    .off_i      (req_off),
    .data_o     (sel_data)
  );

  // output stage next-state
  always_comb begin
    valid_n = rd_act && (load || (hit && !busy));
    data_en = valid_n;
    data_n  = sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_n;
      if (data_en) rd_data <= data_n;
    end
  end

  assign arr_req  = busy;
  assign arr_page = fetch_page;
endmodule

// File: rtl/prb_checks.sv
module prb_checks #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RAND_LAT = 4,
  parameter int unsigned PG_W     = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sel,
  input logic              out_en,
  input logic              byte_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              arr_req,
  input logic [PG_W-1:0]   arr_page
);
  localparam int unsigned RUN_W = $clog2(RAND_LAT + 2);

  logic [PG_W-1:0]  cur_page, pg_prev;
  logic             req_prev;
  logic [RUN_W-1:0] run_q, run_now;

  assign cur_page = rd_addr[ADDR_W-1:ADDR_W-PG_W];

  // consecutive cycles of one fetch on one page
  always_comb begin
    if (!arr_req)                              run_now = '0;
    else if (req_prev && arr_page == pg_prev)  run_now = RUN_W'(run_q + 1'b1);
    else                                       run_now = RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      pg_prev  <= '0;
      req_prev <= 1'b0;
    end else begin
      run_q    <= run_now;
      pg_prev  <= arr_page;
      req_prev <= arr_req;
    end
  end

  a_r2_fetch_length: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> (run_now <= RUN_W'(RAND_LAT - 1)));

  a_r2_no_valid_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> !rd_valid);

  a_r9_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_sel && out_en) |=> !rd_valid);

  a_r10_deselect_abandons: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !arr_req);

  a_r8_restart_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && chip_sel && cur_page != arr_page) |=>
      (!rd_valid && arr_req && arr_page == $past(cur_page)));

  a_r11_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && chip_sel && cur_page == arr_page) |=> $stable(arr_page));

  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && out_en && byte_mode) |=> (!rd_valid || rd_data[DATA_W-1:8] == '0));
endmodule

bind page_read_buffer prb_checks #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .RAND_LAT(RAND_LAT),
  .PG_W    (PG_W)
) u_prb_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_sel (chip_sel),
  .out_en   (out_en),
  .byte_mode(byte_mode),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .arr_req  (arr_req),
  .arr_page (arr_page)
);

// File: tb/page_read_buffer_tb.sv
module page_read_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int WORDS  = 4;
  localparam int LAT    = 4;
  localparam int PAGE_W = WORDS * DATA_W;
  localparam int PG_W   = ADDR_W - 3;
  localparam int VEC_W  = PG_W + 5;
  localparam int NVEC   = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              chip_sel, out_en, byte_mode;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, arr_req;
  logic [PG_W-1:0]   arr_page;
  logic [PAGE_W-1:0] arr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_read_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .RAND_LAT(LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .out_en(out_en),
    .byte_mode(byte_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .arr_req(arr_req), .arr_page(arr_page),
    .arr_data(arr_data)
  );

  function automatic logic [DATA_W-1:0] mk_word(logic [PG_W-1:0] pg, int w);
    int v;
    v = int'(pg) * 37 + w * 4369 + 258;
    return DATA_W'(v);
  endfunction

  // array model: page contents are a function of the page number
  always_comb begin
    for (int w = 0; w < WORDS; w++) arr_data[w*DATA_W +: DATA_W] = mk_word(arr_page, w);
  end

  // R6/R7 selection rules
  function automatic logic [DATA_W-1:0] exp_out(logic [PG_W-1:0] pg, logic [2:0] off, logic bm);
    logic [DATA_W-1:0] w;
    if (bm) begin
      w = mk_word(pg, int'(off[2:1]));
      return off[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    end
    return mk_word(pg, int'(off[2:1]));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // drive a read at a falling edge and judge it with the expected latency
  task automatic do_read(logic [PG_W-1:0] pg, logic [2:0] off, logic bm, bit miss, string req);
    chip_sel  = 1'b1;
    out_en    = 1'b1;
    byte_mode = bm;
    rd_addr   = {pg, off};
    if (miss) begin
      for (int i = 1; i < LAT; i++) begin
        @(posedge clk); @(negedge clk);
        chk(rd_valid == 1'b0, req, 32'(rd_valid), 32'd0);
        chk(arr_req == 1'b1 && arr_page == pg, req, 32'(arr_page), 32'(pg));
      end
    end
    @(posedge clk); @(negedge clk);
    chk(rd_valid == 1'b1, req, 32'(rd_valid), 32'd1);
    chk(rd_data == exp_out(pg, off, bm), req, 32'(rd_data), 32'(exp_out(pg, off, bm)));
    if (!miss) chk(arr_req == 1'b0, req, 32'(arr_req), 32'd0);
  endtask

  // {page, offset, byte_mode, miss}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {17'd5,     3'd0, 1'b0, 1'b1},  // R1 R2: first read after reset
    {17'd5,     3'd6, 1'b0, 1'b0},  // R5 R6: word 3
    {17'd5,     3'd2, 1'b0, 1'b0},  // R5 R6: word 1, out of order
    {17'd5,     3'd3, 1'b0, 1'b0},  // R6: bit 0 ignored
    {17'd5,     3'd7, 1'b1, 1'b0},  // R7: top byte
    {17'd5,     3'd0, 1'b1, 1'b0},  // R7: bottom byte
    {17'd9,     3'd4, 1'b0, 1'b1},  // R3: new page
    {17'd9,     3'd5, 1'b1, 1'b0},  // R7: odd byte
    {17'd9,     3'd1, 1'b0, 1'b0},  // R6: bit 0 ignored
    {17'h1FFFF, 3'd0, 1'b0, 1'b1},  // R3: highest page
    {17'h1FFFF, 3'd3, 1'b1, 1'b0},  // R7
    {17'd5,     3'd6, 1'b0, 1'b1}   // R3: old page was replaced
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    chip_sel  = 1'b0;
    out_en    = 1'b0;
    byte_mode = 1'b0;
    rd_addr   = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);
    chk(arr_req == 1'b0, "R1", 32'(arr_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0 && arr_req == 1'b0, "R1", 32'({rd_valid, arr_req}), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][VEC_W-1:5], VEC[i][4:2], VEC[i][1], VEC[i][0], "R2 R3 R5 R6 R7 table");
    end

    // R9: output enable low blanks the strobe but keeps the buffer
    out_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rd_valid == 1'b0, "R9", 32'(rd_valid), 32'd0);
    do_read(17'd5, 3'd4, 1'b0, 1'b0, "R9");

    // R4: deselect and reselect the same page
    chip_sel = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rd_valid == 1'b0, "R4", 32'(rd_valid), 32'd0);
    do_read(17'd5, 3'd4, 1'b0, 1'b1, "R4");

    // R8: page changes two edges into a fetch
    rd_addr = {17'd20, 3'd0};
    @(posedge clk); @(negedge clk);
    chk(arr_page == 17'd20, "R8", 32'(arr_page), 32'd20);
    @(posedge clk); @(negedge clk);
    do_read(17'd21, 3'd2, 1'b0, 1'b1, "R8");

    // R10: deselect one edge into a fetch
    rd_addr = {17'd30, 3'd0};
    @(posedge clk); @(negedge clk);
    chk(arr_req == 1'b1, "R10", 32'(arr_req), 32'd1);
    chip_sel = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(arr_req == 1'b0, "R10", 32'(arr_req), 32'd0);
    chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'd0);
    do_read(17'd30, 3'd5, 1'b1, 1'b1, "R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule